// File: doc/BRIEF.md
# Banked GPIO Expander Register File

This block is the register core of a parallel-port GPIO expander. A host reaches it over a synchronous, byte-wide register bus that has an address, write data, a write strobe, a read strobe and read data. The block keeps per-port byte registers for output value, polarity inversion and direction. It also holds configuration for pull resistors, drive strength and push-pull or open-drain output mode. From these registers it drives the per-line pad controls. It resynchronises the pad inputs and returns them, corrected for polarity, through an input bank.

The four basic banks sit at bank index times a stride. The stride is the smallest power of two that holds one byte per 8-line port, so unused addresses remain between banks. The configuration banks live in a second region based at 0x40 and use the same stride. Output mode combines a port-wide open-drain bit with a per-line override that flips it. The line count is a parameter with supported values 8, 16 and 24.

Top module: `gpx_regfile`

## Requirements
- R1: Let S be the smallest power of two not below NUM_LINES/8. The input, output, invert and direction banks then sit at 0, S, 2S and 3S, with byte p of a bank serving lines 8p..8p+7 (for 24 lines: 0x00, 0x04, 0x08, 0x0C).
- R2: A read of the input bank returns the pad value XOR the invert register. A pad change reaches the synchronized sample after two clock edges.
- R3: A write to an input bank address changes no register and no output.
- R4: Direction bit 1 makes a line an input, so that line's oe_o is 0. Reset values are: output 0x00, invert 0x00, direction 0xFF, pull enable 0x00, pull select 0x00, all strength codes 11, port mode 0x00, line override 0x00.
- R5: A push-pull line with direction 0 has oe_o = 1 and out_val_o equal to its output register bit.
- R6: The effective open-drain select of line i is the mode bit of port i/8 XOR override bit i. In open-drain, an output bit of 1 gives oe_o = 0, and an output bit of 0 gives oe_o = 1 with out_val_o = 0.
- R7: Pull enable sits at 0x40+3S and pull select at 0x40+4S, with one bit per line. pull_up_o = 1 selects pull-up and 0 selects pull-down.
- R8: Drive strength uses 2 bits per line. Strength byte k holds lines 4k..4k+3, with line 4k+j at bits 2j+1:2j. Bytes 0..P-1 sit at 0x40+k and bytes P..2P-1 at 0x40+S+(k-P). Codes 00, 01, 10 and 11 select quarter, half, three-quarter and full drive.
- R9: The port mode register at 0x4F holds bit p for port p (1 = open-drain) and reads back only the implemented bits. The line override bank sits at 0x60+p.
- R10: Reads of gap or unmapped addresses return 0x00 and writes to them have no effect (for 24 lines this covers 0x03, 0x07, 0x48, 0x80).
- R11: Read data is registered one cycle after rd_i and holds its value while rd_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 8 | Register byte address |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Registered read data |
| pad_i | input | NUM_LINES | Raw pad input levels |
| out_val_o | output | NUM_LINES | Value driven on enabled lines |
| oe_o | output | NUM_LINES | Output driver enable |
| od_o | output | NUM_LINES | Effective open-drain select |
| dir_o | output | NUM_LINES | Direction (1 = input) |
| pull_en_o | output | NUM_LINES | Pull resistor enable |
| pull_up_o | output | NUM_LINES | Pull select (1 = up) |
| strength_o | output | 2*NUM_LINES | Drive strength codes, 2 bits per line |

## Verification
A mis-decoded address or a wrong register bit appears as a pad control that differs from the programmed value. This difference shows on the cycle after the write, on oe_o, out_val_o or od_o, and one cycle later in a read-back. The polarity and synchronizer path is exposed by a read issued three cycles after a pad change. The open-drain combination is checked line by line with a mixed port and override setting, so that a missing XOR or a swapped release polarity shows up on individual oe_o bits. Gap addresses are written and then read to prove that no stray storage exists.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  typedef enum logic [3:0] {
    K_NONE, K_IN, K_OUT, K_INV, K_DIR, K_STR, K_PEN, K_PSEL, K_PMODE, K_LOVR
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e  kind;
    logic [7:0] idx;
  } reg_sel_t;

  localparam logic [7:0] EXT_BASE   = 8'h40;
  localparam logic [7:0] PMODE_ADDR = 8'h4F;
  localparam logic [7:0] LOVR_BASE  = 8'h60;
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpx_addr_dec.sv
module gpx_addr_dec
  import gpx_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int STRIDE    = 4
) (
  input  logic [7:0] addr_i,
  output reg_sel_t   sel_o
);
  localparam int         SLOG   = (STRIDE > 1) ? $clog2(STRIDE) : 0;
  localparam logic [7:0] SMASK  = 8'(STRIDE - 1);
  localparam logic [7:0] NP     = 8'(NUM_PORTS);
  localparam logic [7:0] BASIC_END = 8'(4 * STRIDE);
  localparam logic [7:0] EXT_END   = 8'(64 + 5 * STRIDE);

  logic [7:0] rel, bank, off;

  always_comb begin
    sel_o = '{kind: K_NONE, idx: 8'h00};
    rel   = 8'h00;
    bank  = 8'h00;
    off   = 8'h00;
    if (addr_i == PMODE_ADDR) begin
      sel_o.kind = K_PMODE;
    end else if (addr_i < BASIC_END) begin
      bank = addr_i >> SLOG;
      off  = addr_i & SMASK;
      if (off < NP) begin
        sel_o.idx = off;
        case (bank)
          8'd0:    sel_o.kind = K_IN;
          8'd1:    sel_o.kind = K_OUT;
          8'd2:    sel_o.kind = K_INV;
          default: sel_o.kind = K_DIR;
        endcase
      end
    end else if (addr_i >= EXT_BASE && addr_i < EXT_END) begin
      rel  = addr_i - EXT_BASE;
      bank = rel >> SLOG;
      off  = rel & SMASK;
      if (off < NP) begin
        case (bank)
          8'd0: begin sel_o.kind = K_STR;  sel_o.idx = off;      end
          8'd1: begin sel_o.kind = K_STR;  sel_o.idx = off + NP; end
          8'd3: begin sel_o.kind = K_PEN;  sel_o.idx = off;      end
          8'd4: begin sel_o.kind = K_PSEL; sel_o.idx = off;      end
          default: sel_o.kind = K_NONE;  // latch/interrupt banks unmapped here
        endcase
      end
    end else if (addr_i >= LOVR_BASE && addr_i < LOVR_BASE + NP) begin
      sel_o.kind = K_LOVR;
      sel_o.idx  = addr_i - LOVR_BASE;
    end
  end
endmodule

// File: rtl/gpx_pad_ctrl.sv
module gpx_pad_ctrl #(
  parameter int NUM_LINES = 24,
  localparam int NUM_PORTS = NUM_LINES / 8
) (
  input  logic [NUM_LINES-1:0] out_i,
  input  logic [NUM_LINES-1:0] dir_i,
  input  logic [NUM_PORTS-1:0] pmode_i,
  input  logic [NUM_LINES-1:0] ovr_i,
  output logic [NUM_LINES-1:0] out_val_o,
  output logic [NUM_LINES-1:0] oe_o,
  output logic [NUM_LINES-1:0] od_o
);
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic od;
    assign od           = pmode_i[i/8] ^ ovr_i[i];
    assign od_o[i]      = od;
    // open-drain: a 1 releases the line, a 0 pulls it low
    assign oe_o[i]      = ~dir_i[i] & ~(od & out_i[i]);
    assign out_val_o[i] = out_i[i] & ~od;
  end
endmodule

// File: rtl/gpx_regfile.sv
module gpx_regfile
  import gpx_pkg::*;
#(
  parameter int NUM_LINES = 24
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [7:0]             addr_i,
  input  logic [7:0]             wdata_i,
  input  logic                   wr_i,
  input  logic                   rd_i,
  output logic [7:0]             rdata_o,
  input  logic [NUM_LINES-1:0]   pad_i,
  output logic [NUM_LINES-1:0]   out_val_o,
  output logic [NUM_LINES-1:0]   oe_o,
  output logic [NUM_LINES-1:0]   od_o,
  output logic [NUM_LINES-1:0]   dir_o,
  output logic [NUM_LINES-1:0]   pull_en_o,
  output logic [NUM_LINES-1:0]   pull_up_o,
  output logic [2*NUM_LINES-1:0] strength_o
);
  localparam int NUM_PORTS = NUM_LINES / 8;
  localparam int STRIDE    = (NUM_PORTS > 1) ? (1 << $clog2(NUM_PORTS)) : 1;
  localparam int NUM_STR   = 2 * NUM_PORTS;

  reg_sel_t sel;
  logic [NUM_LINES-1:0] pad_sync;
  logic [NUM_LINES-1:0] out_q, inv_q, dir_q, pen_q, psel_q, ovr_q;
  logic [2*NUM_LINES-1:0] str_q;
  logic [NUM_PORTS-1:0] pmode_q;
  logic [7:0] rd_val, rdata_q;

  gpx_addr_dec #(.NUM_PORTS(NUM_PORTS), .STRIDE(STRIDE)) u_dec (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  gpx_sync #(.WIDTH(NUM_LINES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_i),
    .q_o    (pad_sync)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic hit;
    assign hit = wr_i && (sel.idx == 8'(p));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        out_q[p*8 +: 8]  <= 8'h00;
        inv_q[p*8 +: 8]  <= 8'h00;
        dir_q[p*8 +: 8]  <= 8'hFF;
        pen_q[p*8 +: 8]  <= 8'h00;
        psel_q[p*8 +: 8] <= 8'h00;
        ovr_q[p*8 +: 8]  <= 8'h00;
      end else if (hit) begin
        case (sel.kind)
          K_OUT:   out_q[p*8 +: 8]  <= wdata_i;
          K_INV:   inv_q[p*8 +: 8]  <= wdata_i;
          K_DIR:   dir_q[p*8 +: 8]  <= wdata_i;
          K_PEN:   pen_q[p*8 +: 8]  <= wdata_i;
          K_PSEL:  psel_q[p*8 +: 8] <= wdata_i;
          K_LOVR:  ovr_q[p*8 +: 8]  <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  for (genvar k = 0; k < NUM_STR; k++) begin : g_str
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        str_q[k*8 +: 8] <= 8'hFF;
      else if (wr_i && sel.kind == K_STR && sel.idx == 8'(k))
        str_q[k*8 +: 8] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          pmode_q <= '0;
    else if (wr_i && sel.kind == K_PMODE) pmode_q <= wdata_i[NUM_PORTS-1:0];
  end

  always_comb begin
    rd_val = 8'h00;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (sel.idx == 8'(p)) begin
        case (sel.kind)
          K_IN:    rd_val = pad_sync[p*8 +: 8] ^ inv_q[p*8 +: 8];
          K_OUT:   rd_val = out_q[p*8 +: 8];
          K_INV:   rd_val = inv_q[p*8 +: 8];
          K_DIR:   rd_val = dir_q[p*8 +: 8];
          K_PEN:   rd_val = pen_q[p*8 +: 8];
          K_PSEL:  rd_val = psel_q[p*8 +: 8];
          K_LOVR:  rd_val = ovr_q[p*8 +: 8];
          default: ;
        endcase
      end
    end
    for (int k = 0; k < NUM_STR; k++)
      if (sel.kind == K_STR && sel.idx == 8'(k)) rd_val = str_q[k*8 +: 8];
    if (sel.kind == K_PMODE) rd_val[NUM_PORTS-1:0] = pmode_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= 8'h00;
    else if (rd_i) rdata_q <= rd_val;
  end

  gpx_pad_ctrl #(.NUM_LINES(NUM_LINES)) u_pad (
    .out_i     (out_q),
    .dir_i     (dir_q),
    .pmode_i   (pmode_q),
    .ovr_i     (ovr_q),
    .out_val_o (out_val_o),
    .oe_o      (oe_o),
    .od_o      (od_o)
  );

  assign rdata_o    = rdata_q;
  assign dir_o      = dir_q;
  assign pull_en_o  = pen_q;
  assign pull_up_o  = psel_q;
  assign strength_o = str_q;
endmodule

// File: rtl/gpx_regfile_chk.sv
module gpx_regfile_chk #(
  parameter int NUM_LINES = 24
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [7:0]           addr_i,
  input logic [7:0]           wdata_i,
  input logic                 wr_i,
  input logic                 rd_i,
  input logic [7:0]           rdata_o,
  input logic [NUM_LINES-1:0] out_val_o,
  input logic [NUM_LINES-1:0] oe_o,
  input logic [NUM_LINES-1:0] od_o,
  input logic [NUM_LINES-1:0] dir_o
);
  localparam int NUM_PORTS = NUM_LINES / 8;
  localparam int STRIDE    = (NUM_PORTS > 1) ? (1 << $clog2(NUM_PORTS)) : 1;
  localparam logic [7:0] OUT0 = 8'(STRIDE);

  p_input_dir_no_drive_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_o & dir_o) == '0);

  p_od_never_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (od_o & out_val_o) == '0);

  p_input_write_ignored_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i < 8'(NUM_PORTS)) |=> ($stable(out_val_o) && $stable(oe_o) && $stable(dir_o)));

  p_unmapped_read_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i >= 8'h80) |=> (rdata_o == 8'h00));

  p_rdata_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));

  p_out_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OUT0 && od_o[7:0] == 8'h00) |=> (out_val_o[7:0] == $past(wdata_i)));
endmodule

bind gpx_regfile gpx_regfile_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .wr_i      (wr_i),
  .rd_i      (rd_i),
  .rdata_o   (rdata_o),
  .out_val_o (out_val_o),
  .oe_o      (oe_o),
  .od_o      (od_o),
  .dir_o     (dir_o)
);

// File: tb/tb_gpx_regfile.sv
module tb_gpx_regfile;
  localparam int N = 24;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [7:0] addr_i = '0, wdata_i = '0;
  logic wr_i = 1'b0, rd_i = 1'b0;
  logic [7:0] rdata_o;
  logic [N-1:0] pad_i = '0;
  logic [N-1:0] out_val_o, oe_o, od_o, dir_o, pull_en_o, pull_up_o;
  logic [2*N-1:0] strength_o;

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  bit pend = 0, done = 0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  gpx_regfile #(.NUM_LINES(N)) dut (.*);

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(posedge clk_i); #2;
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i); #2;
    wr_i = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [7:0] exp, string tag);
    @(posedge clk_i); #2;
    rd_i = 1'b1; addr_i = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(posedge clk_i); #2;
    rd_i = 1'b0;
  endtask

  // monitor: read issued before negedge n is compared at negedge n+1
  always @(negedge clk_i) begin
    if (pend) begin
      if (exp_q.size() == 0) chk("R11 unexpected read", 64'(rdata_o), 64'h0);
      else chk(tag_q.pop_front(), 64'(rdata_o), 64'(exp_q.pop_front()));
    end
    pend = rd_i;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #2 rst_ni = 1'b1;
    #5;
    // R4 reset state
    chk("R4 reset dir", 64'(dir_o), 64'hFFFFFF);
    chk("R4 reset oe", 64'(oe_o), 64'h0);
    chk("R8 reset strength full", 64'(strength_o), 64'hFFFF_FFFF_FFFF);
    chk("R7 reset pull", 64'({pull_en_o, pull_up_o}), 64'h0);
    rd(8'h0C, 8'hFF, "R4 reset dir read");
    rd(8'h05, 8'h00, "R4 reset out read");

    // R1 R5 output bank and push-pull drive
    wr(8'h04, 8'hA5); wr(8'h05, 8'h3C); wr(8'h06, 8'h0F);
    wr(8'h0C, 8'h00);
    chk("R5 oe port0", 64'(oe_o), 64'h0000FF);
    chk("R5 out_val", 64'(out_val_o), 64'h0F3CA5);
    rd(8'h04, 8'hA5, "R1 out port0");
    rd(8'h06, 8'h0F, "R1 out port2");
    rd(8'h0C, 8'h00, "R1 dir port0");

    // R2 input with polarity
    pad_i = 24'h123456;
    repeat (3) @(posedge clk_i);
    rd(8'h00, 8'h56, "R2 in port0");
    rd(8'h02, 8'h12, "R2 in port2");
    wr(8'h09, 8'hFF);
    rd(8'h01, 8'hCB, "R2 in port1 inverted");
    rd(8'h09, 8'hFF, "R1 inv port1");

    // R3 writes to the input bank ignored
    wr(8'h00, 8'h77);
    chk("R3 out_val unchanged", 64'(out_val_o), 64'h0F3CA5);
    chk("R3 oe unchanged", 64'(oe_o), 64'h0000FF);
    rd(8'h00, 8'h56, "R3 in port0 still pad");
    rd(8'h04, 8'hA5, "R3 out port0 unchanged");

    // R10 gaps and unmapped
    wr(8'h03, 8'hFF); wr(8'h07, 8'hFF); wr(8'h48, 8'hFF); wr(8'h80, 8'hFF);
    rd(8'h03, 8'h00, "R10 gap 0x03");
    rd(8'h07, 8'h00, "R10 gap 0x07");
    rd(8'h48, 8'h00, "R10 unmapped 0x48");
    rd(8'h80, 8'h00, "R10 unmapped 0x80");
    chk("R10 outputs unchanged", 64'(out_val_o), 64'h0F3CA5);

    // R8 drive strength
    wr(8'h40, 8'h1B);
    chk("R8 lines0-3 codes", 64'(strength_o[7:0]), 64'h1B);
    wr(8'h44, 8'hE4);
    chk("R8 lines12-15 from second bank", 64'(strength_o[31:24]), 64'hE4);
    rd(8'h44, 8'hE4, "R8 read bank1");

    // R7 pull enable and select
    wr(8'h4C, 8'hF0); wr(8'h50, 8'hAA);
    chk("R7 pull_en", 64'(pull_en_o), 64'h0000F0);
    chk("R7 pull_up", 64'(pull_up_o), 64'h0000AA);
    rd(8'h50, 8'hAA, "R7 read psel");

    // R6 R9 open-drain and override
    wr(8'h4F, 8'h01);
    chk("R6 od port0", 64'(od_o), 64'h0000FF);
    chk("R6 oe od port0", 64'(oe_o), 64'h00005A);
    chk("R6 out_val od", 64'(out_val_o), 64'h0F3C00);
    wr(8'h60, 8'h0F);
    chk("R6 od override", 64'(od_o), 64'h0000F0);
    chk("R6 oe mixed", 64'(oe_o), 64'h00005F);
    chk("R6 out_val mixed", 64'(out_val_o), 64'h0F3C05);
    rd(8'h4F, 8'h01, "R9 pmode read");
    wr(8'h4F, 8'hFF);
    rd(8'h4F, 8'h07, "R9 pmode implemented bits");
    rd(8'h60, 8'h0F, "R9 override read");

    // R11 hold
    repeat (4) @(posedge clk_i);
    #3 chk("R11 rdata held", 64'(rdata_o), 64'h0F);

    repeat (3) @(posedge clk_i);
    chk("R11 queue drained", 64'(exp_q.size()), 64'h0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule